// File: doc/BRIEF.md
# Two-Wire Serial Target with Eight-Register Bank

This block is the target side of a two-wire serial bus (clock and data lines, open-drain, pulled high). A bus controller reaches eight byte-wide registers through it. The registers live outside the block and are reached through a simple register-file port. The block samples the clock and data lines with its own system clock. From those samples it finds start, repeated-start and stop conditions. It answers only to its own 7-bit device address.

Register access runs through one address pointer. This pointer is shared by reads and writes and keeps its value between transactions. In a write transaction, the first byte after the device address loads the pointer, and each later byte is stored at the pointed register. A read transaction with no address phase (a current-address read) carries on from where the last access left the pointer. To read a chosen register (a random read), the controller first sets the pointer with a write that carries no data, then sends a repeated start and switches to read. After each data byte, read or written, the pointer steps forward and wraps from the last register back to the first.

Top module: `i2c_reg_target`

## Requirements
- R1: A start is data falling while clock is high, and a stop is data rising while clock is high. A start at any point, even in the middle of a byte, returns the block to the device-address phase. A stop returns it to idle. A partly received byte is dropped and causes no register write. The block does not drive the data line after reset.
- R2: The first byte after a start is received most significant bit first. Bits 7:1 are the device address and bit 0 is the direction, 1 for read and 0 for write. When bits 7:1 equal `DEV_ADDR`, the block acknowledges by pulling data low (`sdaOe` = 1) for the ninth clock of that byte.
- R3: When the address does not match, the block does not acknowledge. It then neither drives data nor writes a register until the next start.
- R4: In a write, every byte is acknowledged. The first byte after the address loads the pointer from its low `PTR_W` bits. Each following byte gives exactly one `regWrEn` pulse, with `regAddr` at the pointer and `regWrData` at the byte.
- R5: The pointer steps by one after every data byte that is read or written, but not after the byte that loads it. From `NUM_REGS`-1 (7) it wraps to 0, so the next byte read returns register 0.
- R6: The pointer is 0 after reset. A current-address read returns the register at the pointer, which is the one after the last register read or written.
- R7: A random read is: start, address with write, pointer byte, repeated start, address with read. It returns the register that the pointer byte selected, and then the registers after it.
- R8: While the block sends, a controller acknowledge (data low on the ninth clock) makes it send the next register. A not-acknowledge makes it release data and leave the bus alone until the next start.
- R9: The block changes `sdaOe` only while the clock line is low. `sdaOe` = 1 pulls data low and `sdaOe` = 0 releases it for a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Open-drain enable; 1 pulls data low |
| regAddr | output | PTR_W | Pointer, addresses the register file |
| regWrEn | output | 1 | One-cycle write strobe to the register file |
| regWrData | output | 8 | Byte to store at `regAddr` |
| regRdData | input | 8 | Register-file contents at `regAddr` |

## Verification
The bench builds the block with its default parameters: device address 2Ch, eight registers, a 6-bit pointer and two synchroniser stages. The bus clock runs at one sixteenth of the system clock. With eight registers, the wrap from 7 to 0 comes within a few bytes of almost any start point, so both random multi-byte transfers and directed ones cross it often. The slow bus clock leaves room for the synchroniser and edge-detect latency before each data change. Directed cases cover the rest: a foreign address, a start or stop in the middle of a byte, and a not-acknowledge followed by more clocks.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_DACK,
    ST_TX,
    ST_TACK
  } tgtState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ptrLoad;
    logic ptrInc;
    logic regWr;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_reg_busmon.sv
module i2c_reg_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclHigh,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond
);
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  // Bus idles high, so every stage resets to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclHigh   = sclPipe[SYNC_STAGES-1];
  assign sdaBit    = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclHigh & ~sclPrev;
  assign sclFall   = ~sclHigh & sclPrev;
  assign startCond = sclHigh & sclPrev & sdaPrev & ~sdaBit;
  assign stopCond  = sclHigh & sclPrev & ~sdaPrev & sdaBit;
endmodule

// File: rtl/i2c_reg_dpath.sv
module i2c_reg_dpath
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] shiftReg,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [PTR_W-1:0]  ptr
);
  localparam logic [PTR_W-1:0] LAST_REG = PTR_W'(NUM_REGS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.txLoad) begin
      shiftReg <= regRdData;
    end else if (stb.rxShift) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
    end else if (stb.txShift) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (stb.cntClr) begin
      bitCnt <= '0;
    end else if (stb.cntInc) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  // Shared pointer: load from the first write byte, step with wrap otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.ptrLoad) begin
      ptr <= shiftReg[PTR_W-1:0];
    end else if (stb.ptrInc) begin
      ptr <= (ptr == LAST_REG) ? '0 : ptr + PTR_W'(1);
    end
  end

  // R2: a byte never holds more than eight bits
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);
endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclHigh,
  input  logic              sdaBit,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startCond,
  input  logic              stopCond,
  input  logic [BYTE_W-1:0] shiftReg,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic              rdMsb,
  output dpStrobe_t         stb,
  output logic              sdaOe
);
  tgtState_e state, stateNext;
  logic oeNext;
  logic rdMode, rdNext;
  logic firstByte, firstNext;
  logic ackSeen, ackNext;
  logic byteDone;

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));

  always_comb begin
    stb       = '0;
    stateNext = state;
    oeNext    = sdaOe;
    rdNext    = rdMode;
    firstNext = firstByte;
    ackNext   = ackSeen;
    if (startCond) begin
      stateNext  = ST_ADDR;
      oeNext     = 1'b0;
      stb.cntClr = 1'b1;
    end else if (stopCond) begin
      stateNext  = ST_IDLE;
      oeNext     = 1'b0;
      stb.cntClr = 1'b1;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) begin
            stb.rxShift = 1'b1;
            stb.cntInc  = 1'b1;
          end else if (sclFall && byteDone) begin
            stb.cntClr = 1'b1;
            if (shiftReg[BYTE_W-1:1] == DEV_ADDR) begin
              stateNext = ST_AACK;
              oeNext    = 1'b1;
              rdNext    = shiftReg[0];
              firstNext = 1'b1;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            if (rdMode) begin
              stb.txLoad = 1'b1;
              stb.ptrInc = 1'b1;
              stateNext  = ST_TX;
              oeNext     = ~rdMsb;
            end else begin
              stateNext = ST_RX;
              oeNext    = 1'b0;
            end
          end
        end
        ST_RX: begin
          if (sclRise) begin
            stb.rxShift = 1'b1;
            stb.cntInc  = 1'b1;
          end else if (sclFall && byteDone) begin
            stb.cntClr = 1'b1;
            stateNext  = ST_DACK;
            oeNext     = 1'b1;
            if (firstByte) begin
              stb.ptrLoad = 1'b1;
              firstNext   = 1'b0;
            end else begin
              stb.regWr  = 1'b1;
              stb.ptrInc = 1'b1;
            end
          end
        end
        ST_DACK: begin
          if (sclFall) begin
            stateNext = ST_RX;
            oeNext    = 1'b0;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            stb.cntInc = 1'b1;
          end else if (sclFall) begin
            if (byteDone) begin
              stb.cntClr = 1'b1;
              stateNext  = ST_TACK;
              oeNext     = 1'b0;
            end else begin
              stb.txShift = 1'b1;
              oeNext      = ~shiftReg[BYTE_W-2];
            end
          end
        end
        ST_TACK: begin
          if (sclRise) begin
            ackNext = ~sdaBit;
          end else if (sclFall) begin
            if (ackSeen) begin
              stb.txLoad = 1'b1;
              stb.ptrInc = 1'b1;
              stateNext  = ST_TX;
              oeNext     = ~rdMsb;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sdaOe     <= 1'b0;
      rdMode    <= 1'b0;
      firstByte <= 1'b0;
      ackSeen   <= 1'b0;
    end else begin
      state     <= stateNext;
      sdaOe     <= oeNext;
      rdMode    <= rdNext;
      firstByte <= firstNext;
      ackSeen   <= ackNext;
    end
  end

  // R9: the data line is only touched while the clock line is low
  assert_oe_stable_scl_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sclHigh && $past(sclHigh)) |-> $stable(sdaOe));

  // R3: nothing is driven while idle (foreign address, after stop or nack)
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // R1: a start always lands in the address phase with data released
  assert_start_abort_R1: assert property (@(posedge clk) disable iff (!rstN)
    startCond |=> (state == ST_ADDR && !sdaOe));

  // R8: the controller's acknowledge slot is never driven by the target
  assert_tack_released_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TACK) |-> !sdaOe);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         NUM_REGS    = 8,
  parameter int         PTR_W       = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);
  localparam logic [PTR_W-1:0] LAST_REG = PTR_W'(NUM_REGS - 1);

  logic sclHigh, sdaBit, sclRise, sclFall, startCond, stopCond;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [PTR_W-1:0]  ptr;
  dpStrobe_t         stb;

  i2c_reg_busmon #(.SYNC_STAGES(SYNC_STAGES)) i_busmon (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclHigh(sclHigh), .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond)
  );

  i2c_reg_ctrl #(.DEV_ADDR(DEV_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclHigh(sclHigh), .sdaBit(sdaBit),
    .sclRise(sclRise), .sclFall(sclFall), .startCond(startCond), .stopCond(stopCond),
    .shiftReg(shiftReg), .bitCnt(bitCnt), .rdMsb(regRdData[BYTE_W-1]),
    .stb(stb), .sdaOe(sdaOe)
  );

  i2c_reg_dpath #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit), .regRdData(regRdData),
    .shiftReg(shiftReg), .bitCnt(bitCnt), .ptr(ptr)
  );

  assign regAddr   = ptr;
  assign regWrEn   = stb.regWr;
  assign regWrData = shiftReg;

  // R5: every written byte moves the pointer on by one, wrapping after the last register
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == (($past(regAddr) == LAST_REG) ? '0 : $past(regAddr) + PTR_W'(1))));

  // R4: a stored byte is acknowledged in the following bus clock
  assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> sdaOe);
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam logic [6:0] DEV   = 7'h2C;
  localparam logic [6:0] OTHER = 7'h2D;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaOe;
  logic [5:0] regAddr;
  logic regWrEn;
  logic [7:0] regWrData, regRdData;
  logic [7:0] regFile [8];
  logic [7:0] expRegs [8];
  logic [5:0] expPtr;
  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  int oeCount = 0;
  int seedDummy;

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~sdaOe;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [7:0] initVal(int i);
    return 8'(8'h5A ^ (i * 37));
  endfunction

  function automatic logic [5:0] nextPtr(logic [5:0] p);
    return (p == 6'd7) ? 6'd0 : p + 6'd1;
  endfunction

  // Bench-side register file behind the block's port
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) regFile[i] <= initVal(i);
    end else begin
      if (regWrEn && regAddr < 6'd8) regFile[regAddr[2:0]] <= regWrData;
      if (regWrEn) wrCount <= wrCount + 1;
      if (sdaOe) oeCount <= oeCount + 1;
    end
  end
  assign regRdData = (regAddr < 6'd8) ? regFile[regAddr[2:0]] : 8'h00;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b0; waitClk(HALF);
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b1; waitClk(HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      sdaM = b[i]; waitClk(HALF);
      sclM = 1'b1; waitClk(HALF);
      sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF / 2);
    acked = ~sdaBus;
    waitClk(HALF / 2);
    sclM = 1'b0;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF);
      sclM = 1'b1; waitClk(HALF / 2);
      d[i] = sdaBus;
      waitClk(HALF / 2);
      sclM = 1'b0;
    end
    sdaM = ~giveAck; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sclM = 1'b0;
  endtask

  task automatic readBurst(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, d);
      chk((expPtr == 6'd0 && k > 0) ? "R5" : tag, "read data", d, expRegs[expPtr[2:0]]);
      expPtr = nextPtr(expPtr);
    end
  endtask

  task automatic doWrite(input logic [7:0] p, input int n);
    logic acked;
    logic [7:0] d;
    int wrBefore;
    wrBefore = wrCount;
    busStart;
    sendByte({DEV, 1'b0}, acked);
    chk("R2", "write address ack", acked, 1);
    sendByte(p, acked);
    chk("R4", "pointer byte ack", acked, 1);
    expPtr = p[5:0];
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, acked);
      chk("R4", "data byte ack", acked, 1);
      expRegs[expPtr[2:0]] = d;
      expPtr = nextPtr(expPtr);
    end
    busStop;
    chk("R4", "write strobe count", wrCount - wrBefore, n);
  endtask

  task automatic doCurRead(input int n);
    logic acked;
    busStart;
    sendByte({DEV, 1'b1}, acked);
    chk("R2", "read address ack", acked, 1);
    readBurst(n, "R6");
    busStop;
  endtask

  task automatic doRandRead(input logic [7:0] p, input int n);
    logic acked;
    busStart;
    sendByte({DEV, 1'b0}, acked);
    chk("R7", "dummy write address ack", acked, 1);
    sendByte(p, acked);
    chk("R7", "pointer byte ack", acked, 1);
    expPtr = p[5:0];
    busStart;
    sendByte({DEV, 1'b1}, acked);
    chk("R7", "read address ack", acked, 1);
    readBurst(n, "R7");
    busStop;
  endtask

  initial begin
    seedDummy = $urandom(32'h1C2D3E);
    for (int i = 0; i < 8; i++) expRegs[i] = initVal(i);
    expPtr = 6'd0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    chk("R1", "sdaOe after reset", sdaOe, 0);
    chk("R6", "pointer after reset", regAddr, 0);

    // Current read from reset pointer
    doCurRead(2);

    // Write across the top of the bank, then verify with a random read
    doWrite(8'd6, 4);
    chk("R5", "pointer after wrapping write", regAddr, 2);
    doCurRead(1);
    doRandRead(8'd5, 6);

    // Foreign address: no ack, no drive, no writes
    begin
      logic acked;
      int oeBefore, wrBefore;
      busStart;
      sendByte({OTHER, 1'b0}, acked);
      chk("R3", "foreign address ack", acked, 0);
      oeBefore = oeCount;
      wrBefore = wrCount;
      for (int k = 0; k < 3; k++) begin
        sendByte(8'h00, acked);
        chk("R3", "byte after foreign address ack", acked, 0);
      end
      busStop;
      chk("R3", "drive cycles after foreign address", oeCount - oeBefore, 0);
      chk("R3", "writes after foreign address", wrCount - wrBefore, 0);
      doRandRead(8'd0, 8);
    end

    // Repeated start inside a data byte drops it
    begin
      logic acked;
      logic [7:0] d;
      int wrBefore;
      wrBefore = wrCount;
      busStart;
      sendByte({DEV, 1'b0}, acked);
      sendByte(8'd3, acked);
      expPtr = 6'd3;
      sendBits(8'h00, 4);
      busStart;
      sendByte({DEV, 1'b1}, acked);
      chk("R1", "address ack after mid-byte start", acked, 1);
      recvByte(1'b0, d);
      chk("R1", "read after aborted byte", d, expRegs[3]);
      expPtr = nextPtr(expPtr);
      busStop;
      chk("R1", "no write from aborted byte", wrCount - wrBefore, 0);
    end

    // Stop inside a data byte drops it
    begin
      logic acked;
      int wrBefore;
      wrBefore = wrCount;
      busStart;
      sendByte({DEV, 1'b0}, acked);
      sendByte(8'd4, acked);
      expPtr = 6'd4;
      sendBits(8'hFF, 5);
      busStop;
      chk("R1", "no write from stopped byte", wrCount - wrBefore, 0);
      doCurRead(1);
    end

    // Not-acknowledge ends the read; further clocks are ignored
    begin
      logic acked;
      logic [7:0] d;
      int oeBefore;
      busStart;
      sendByte({DEV, 1'b1}, acked);
      recvByte(1'b0, d);
      chk("R8", "single read before nack", d, expRegs[expPtr[2:0]]);
      expPtr = nextPtr(expPtr);
      waitClk(HALF / 2);
      chk("R8", "sdaOe after nack", sdaOe, 0);
      oeBefore = oeCount;
      sendByte(8'hFF, acked);
      chk("R8", "ack slot after nack", acked, 0);
      chk("R8", "drive cycles after nack", oeCount - oeBefore, 0);
      busStop;
      doCurRead(1);
    end

    // Constrained random mix of transactions
    for (int it = 0; it < 30; it++) begin
      int op, n;
      logic [7:0] p;
      op = int'($urandom % 3);
      n  = 1 + int'($urandom % 10);
      p  = 8'($urandom % 8);
      case (op)
        0: doWrite(p, n);
        1: doCurRead(n);
        default: doRandRead(p, n);
      endcase
    end
    chk("R9", "sdaOe idle at end", sdaOe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule